// File: doc/BRIEF.md
# Non-Posted Request Tag Tracker

This block hands out a unique tag to every outgoing request that expects an answer, and it keeps the state of each tag until that request is fully answered. A requester raises `req_valid` with the total byte count it expects back. In the same cycle the block offers the lowest-numbered free tag and marks it busy at the next clock edge. While no tag is free, the grant is withheld and an exhausted flag is raised.

Incoming completions present a tag, a 3-bit status, the byte count still outstanding (this completion's payload included) and the payload byte count. A request may be answered by several split completions. The block reduces its per-tag expected count on each partial answer. It frees the tag when a completion's remaining count equals its own payload, or when the completion reports a status other than success. Completions for idle tags, byte-count disagreements and requests that stay open for too long are reported on a single error pulse that carries a reason code. A running count of outstanding requests is kept.

Top module: `np_tag_tracker`

## Requirements
- R1: While `req_valid` is high and a tag is free, `req_grant` is high in the same cycle and `grant_tag` is the lowest-numbered free tag. That tag becomes busy at the next rising edge.
- R2: While all 2^TAG_W tags are busy, `tags_exhausted` is 1 and `req_grant` is 0.
- R3: A busy tag is never granted again until its request has been closed.
- R4: A successful completion (status 000) on a busy tag whose remaining count equals both the tag's expected count and the completion's payload count closes the request. `done_pulse` is high for one cycle after the completion's edge, with `done_tag`, and the tag becomes free.
- R5: A successful completion whose remaining count equals the expected count but differs from its payload count produces no pulse. It lowers the expected count by the payload count, so a later completion with the reduced count closes the request.
- R6: A successful completion on a busy tag whose remaining count differs from the tag's expected count gives `err_pulse` with `err_code` 3 and `err_tag`. The tag's state stays unchanged.
- R7: A completion on a busy tag with any status other than 000 (for example 001 unsupported, 010 configuration retry, 100 completer abort) closes the request. It gives `done_pulse` together with `err_pulse` and `err_code` 4, and frees the tag.
- R8: A completion on a tag that is not busy gives `err_pulse` with `err_code` 1 and the tag. No tracker state changes.
- R9: A tag that stays busy is reported with `err_code` 2 and freed. The report appears `tmo_limit`+1 cycles after its grant edge. Timeouts are reported only in cycles with no completion presented, lowest tag first.
- R10: `outstanding` rises by one on each grant and falls by one on each release. A grant and a release in the same cycle leave it unchanged.
- R11: After reset every tag is free, `outstanding` is 0, `tags_exhausted` is 0 and no pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_limit | input | TMO_W | Timeout window in cycles |
| req_valid | input | 1 | Request for a tag |
| req_bytes | input | BC_W | Total bytes the request expects back |
| req_grant | output | 1 | Tag granted this cycle |
| grant_tag | output | TAG_W | Granted tag |
| tags_exhausted | output | 1 | No tag free |
| cpl_valid | input | 1 | Completion presented |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_status | input | 3 | Completion status |
| cpl_remain | input | BC_W | Bytes remaining, this payload included |
| cpl_len | input | BC_W | Payload bytes of this completion |
| done_pulse | output | 1 | Request closed |
| done_tag | output | TAG_W | Tag of closed request |
| err_pulse | output | 1 | Error reported |
| err_code | output | 3 | 1 spurious, 2 timeout, 3 byte count, 4 bad status |
| err_tag | output | TAG_W | Tag the error concerns |
| outstanding | output | TAG_W+1 | Busy tag count |

## Verification
The assertions assume well-formed completions. The payload count is never larger than the remaining count, and request byte counts are nonzero. They also assume `tmo_limit` changes only while no request is outstanding. The directed stimulus keeps to these rules: it changes the timeout window only after every tag has been released. Every partial completion it sends carries a payload smaller than the remaining count. The only deliberate byte-count disagreement it sends is the one used to provoke the byte-count error.

// File: rtl/np_tag_pkg.sv
package np_tag_pkg;
   typedef enum logic [2:0] {
      ERR_NONE     = 3'd0,
      ERR_SPURIOUS = 3'd1,
      ERR_TIMEOUT  = 3'd2,
      ERR_BYTECNT  = 3'd3,
      ERR_STATUS   = 3'd4
   } np_err_e;

   localparam logic [2:0] CPL_STATUS_OK = 3'b000;
endpackage

// File: rtl/np_tag_lowest.sv
module np_tag_lowest #(
   parameter int N     = 256,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   generate
      if (N < 2) begin : g_bad
         $error("np_tag_lowest needs N >= 2");
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/np_tag_slots.sv
module np_tag_slots #(
   parameter int TAG_W    = 8,
   parameter int BC_W     = 13,
   parameter int TMO_W    = 20,
   parameter int NUM_TAGS = 1 << TAG_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TMO_W-1:0]    tmo_limit,
   input  logic                alloc_en,
   input  logic [TAG_W-1:0]    alloc_tag,
   input  logic [BC_W-1:0]     alloc_bytes,
   input  logic                part_en,
   input  logic [TAG_W-1:0]    part_tag,
   input  logic [BC_W-1:0]     part_len,
   input  logic                free_en,
   input  logic [TAG_W-1:0]    free_tag,
   input  logic [TAG_W-1:0]    look_tag,
   output logic [BC_W-1:0]     look_expect,
   output logic [NUM_TAGS-1:0] busy_vec,
   output logic [NUM_TAGS-1:0] expired_vec
);
   logic [BC_W-1:0] expect_arr [NUM_TAGS];

   generate
      for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
         logic             busy_q;
         logic [BC_W-1:0]  expect_q;
         logic [TMO_W-1:0] timer_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               busy_q   <= 1'b0;
               expect_q <= '0;
               timer_q  <= '0;
            end else if (alloc_en && alloc_tag == TAG_W'(g)) begin
               busy_q   <= 1'b1;
               expect_q <= alloc_bytes;
               timer_q  <= '0;
            end else if (free_en && free_tag == TAG_W'(g)) begin
               busy_q   <= 1'b0;
            end else begin
               if (part_en && part_tag == TAG_W'(g))
                  expect_q <= expect_q - part_len;
               if (busy_q && timer_q < tmo_limit)
                  timer_q <= timer_q + 1'b1;
            end
         end

         assign busy_vec[g]    = busy_q;
         assign expired_vec[g] = busy_q && (timer_q >= tmo_limit);
         assign expect_arr[g]  = expect_q;
      end
   endgenerate

   assign look_expect = expect_arr[look_tag];

   AST_ALLOC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !busy_vec[alloc_tag]); // R3
   AST_FREE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      free_en |=> !busy_vec[$past(free_tag)]); // R10
endmodule

// File: rtl/np_tag_tracker.sv
module np_tag_tracker
   import np_tag_pkg::*;
#(
   parameter int TAG_W = 8,
   parameter int BC_W  = 13,
   parameter int TMO_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic             req_valid,
   input  logic [BC_W-1:0]  req_bytes,
   output logic             req_grant,
   output logic [TAG_W-1:0] grant_tag,
   output logic             tags_exhausted,
   input  logic             cpl_valid,
   input  logic [TAG_W-1:0] cpl_tag,
   input  logic [2:0]       cpl_status,
   input  logic [BC_W-1:0]  cpl_remain,
   input  logic [BC_W-1:0]  cpl_len,
   output logic             done_pulse,
   output logic [TAG_W-1:0] done_tag,
   output logic             err_pulse,
   output logic [2:0]       err_code,
   output logic [TAG_W-1:0] err_tag,
   output logic [TAG_W:0]   outstanding
);
   localparam int NUM_TAGS = 1 << TAG_W;
   localparam int CNT_W    = TAG_W + 1;

   generate
      if (TAG_W < 1 || TAG_W > 10) begin : g_bad_tag
         $error("TAG_W must be 1..10");
      end
      if (BC_W < 2) begin : g_bad_bc
         $error("BC_W must be at least 2");
      end
      if (TMO_W < 1) begin : g_bad_tmo
         $error("TMO_W must be at least 1");
      end
   endgenerate

   logic [NUM_TAGS-1:0] busy_vec, expired_vec;
   logic                any_free, tmo_hit;
   logic [TAG_W-1:0]    low_free, tmo_tag;
   logic [BC_W-1:0]     cur_expect;

   np_tag_lowest #(.N(NUM_TAGS), .IDX_W(TAG_W)) i_pick_free (
      .vec(~busy_vec), .hit(any_free), .idx(low_free));

   np_tag_lowest #(.N(NUM_TAGS), .IDX_W(TAG_W)) i_pick_tmo (
      .vec(expired_vec), .hit(tmo_hit), .idx(tmo_tag));

   assign tags_exhausted = !any_free;
   assign req_grant      = req_valid && any_free;
   assign grant_tag      = low_free;

   logic tag_busy, st_ok, cpl_spur, cpl_bad_st, cpl_bc_err, cpl_last, cpl_part;
   logic cpl_close, tmo_fire, rel_en;
   logic [TAG_W-1:0] rel_tag;

   always_comb begin
      tag_busy   = busy_vec[cpl_tag];
      st_ok      = (cpl_status == CPL_STATUS_OK);
      cpl_spur   = cpl_valid && !tag_busy;
      cpl_bad_st = cpl_valid && tag_busy && !st_ok;
      cpl_bc_err = cpl_valid && tag_busy && st_ok && (cpl_remain != cur_expect);
      cpl_last   = cpl_valid && tag_busy && st_ok && (cpl_remain == cur_expect)
                   && (cpl_remain == cpl_len);
      cpl_part   = cpl_valid && tag_busy && st_ok && (cpl_remain == cur_expect)
                   && (cpl_remain != cpl_len);
      cpl_close  = cpl_bad_st || cpl_last;
      tmo_fire   = tmo_hit && !cpl_valid;
      rel_en     = cpl_close || tmo_fire;
      rel_tag    = cpl_close ? cpl_tag : tmo_tag;
   end

   np_tag_slots #(.TAG_W(TAG_W), .BC_W(BC_W), .TMO_W(TMO_W), .NUM_TAGS(NUM_TAGS)) i_slots (
      .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
      .alloc_en(req_grant), .alloc_tag(low_free), .alloc_bytes(req_bytes),
      .part_en(cpl_part), .part_tag(cpl_tag), .part_len(cpl_len),
      .free_en(rel_en), .free_tag(rel_tag),
      .look_tag(cpl_tag), .look_expect(cur_expect),
      .busy_vec(busy_vec), .expired_vec(expired_vec));

   np_err_e err_next;
   always_comb begin
      if (cpl_spur)        err_next = ERR_SPURIOUS;
      else if (cpl_bad_st) err_next = ERR_STATUS;
      else if (cpl_bc_err) err_next = ERR_BYTECNT;
      else if (tmo_fire)   err_next = ERR_TIMEOUT;
      else                 err_next = ERR_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_pulse  <= 1'b0;
         done_tag    <= '0;
         err_pulse   <= 1'b0;
         err_code    <= ERR_NONE;
         err_tag     <= '0;
         outstanding <= '0;
      end else begin
         done_pulse <= cpl_close;
         if (cpl_close) done_tag <= cpl_tag;
         err_pulse  <= (err_next != ERR_NONE);
         err_code   <= err_next;
         if (err_next != ERR_NONE) err_tag <= tmo_fire ? tmo_tag : cpl_tag;
         outstanding <= outstanding + CNT_W'(req_grant) - CNT_W'(rel_en);
      end
   end

   AST_EXHAUST_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      tags_exhausted |-> !req_grant); // R2
   AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding == CNT_W'($countones(busy_vec))); // R10
   AST_DONE_FREED: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> !busy_vec[done_tag]); // R4
   AST_TMO_FREED: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pulse && err_code == ERR_TIMEOUT) |-> !busy_vec[err_tag]); // R9
   AST_ERR_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (err_code != ERR_NONE)); // R8
   AST_GNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant && !rel_en) |=> (outstanding == $past(outstanding) + 1'b1)); // R10
endmodule

// File: tb/test_np_tag_tracker.sv
module test_np_tag_tracker;
   localparam int TAG_W = 8;
   localparam int BC_W  = 13;
   localparam int TMO_W = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [TMO_W-1:0] tmo_limit = 20'd5000;
   logic             req_valid = 1'b0;
   logic [BC_W-1:0]  req_bytes = '0;
   logic             req_grant, tags_exhausted;
   logic [TAG_W-1:0] grant_tag;
   logic             cpl_valid = 1'b0;
   logic [TAG_W-1:0] cpl_tag = '0;
   logic [2:0]       cpl_status = '0;
   logic [BC_W-1:0]  cpl_remain = '0;
   logic [BC_W-1:0]  cpl_len = '0;
   logic             done_pulse, err_pulse;
   logic [TAG_W-1:0] done_tag, err_tag;
   logic [2:0]       err_code;
   logic [TAG_W:0]   outstanding;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   np_tag_tracker #(.TAG_W(TAG_W), .BC_W(BC_W), .TMO_W(TMO_W)) i_np_tag_tracker (
      .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
      .req_valid(req_valid), .req_bytes(req_bytes), .req_grant(req_grant),
      .grant_tag(grant_tag), .tags_exhausted(tags_exhausted),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
      .cpl_remain(cpl_remain), .cpl_len(cpl_len),
      .done_pulse(done_pulse), .done_tag(done_tag), .err_pulse(err_pulse),
      .err_code(err_code), .err_tag(err_tag), .outstanding(outstanding));

   task automatic chk(input string rq, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic do_req(input int bytes, output int tag, output int gnt);
      @(negedge clk);
      req_valid = 1'b1;
      req_bytes = BC_W'(bytes);
      #1;
      gnt = int'(req_grant);
      tag = int'(grant_tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // result fields: done, done_tag, err, err_code, err_tag
   task automatic do_cpl(input int tag, input int st, input int rem, input int len,
                         output int dn, output int dt, output int er, output int ec, output int et);
      @(negedge clk);
      cpl_valid  = 1'b1;
      cpl_tag    = TAG_W'(tag);
      cpl_status = 3'(st);
      cpl_remain = BC_W'(rem);
      cpl_len    = BC_W'(len);
      @(negedge clk);
      cpl_valid = 1'b0;
      dn = int'(done_pulse); dt = int'(done_tag);
      er = int'(err_pulse);  ec = int'(err_code); et = int'(err_tag);
   endtask

   task automatic t_reset;
      chk("R11 outstanding", int'(outstanding), 0);
      chk("R11 exhausted", int'(tags_exhausted), 0);
      chk("R11 done", int'(done_pulse), 0);
      chk("R11 err", int'(err_pulse), 0);
   endtask

   task automatic t_lowest;
      int t, g, dn, dt, er, ec, et;
      for (int i = 0; i < 3; i++) begin
         do_req(64, t, g);
         chk("R1 grant", g, 1);
         chk("R1 lowest tag", t, i);
      end
      chk("R10 count up", int'(outstanding), 3);
      do_cpl(1, 0, 64, 64, dn, dt, er, ec, et);
      chk("R4 done", dn, 1);
      chk("R4 done tag", dt, 1);
      chk("R4 no err", er, 0);
      chk("R10 count down", int'(outstanding), 2);
      do_req(64, t, g);
      chk("R3 freed tag reused lowest", t, 1);
      for (int i = 0; i < 3; i++) do_cpl(i, 0, 64, 64, dn, dt, er, ec, et);
      chk("R10 empty", int'(outstanding), 0);
   endtask

   task automatic t_split;
      int t, g, dn, dt, er, ec, et;
      do_req(256, t, g);
      chk("R1 split tag", t, 0);
      do_cpl(0, 0, 256, 128, dn, dt, er, ec, et);
      chk("R5 partial no done", dn, 0);
      chk("R5 partial no err", er, 0);
      do_cpl(0, 0, 200, 64, dn, dt, er, ec, et);
      chk("R6 bytecount err", er, 1);
      chk("R6 bytecount code", ec, 3);
      chk("R6 no done", dn, 0);
      chk("R6 tag kept", int'(outstanding), 1);
      do_cpl(0, 0, 128, 128, dn, dt, er, ec, et);
      chk("R5 final done", dn, 1);
      chk("R5 final tag", dt, 0);
      chk("R5 empty", int'(outstanding), 0);
   endtask

   task automatic t_status;
      int t, g, dn, dt, er, ec, et;
      int sts[3] = '{1, 2, 4};
      foreach (sts[k]) begin
         do_req(512, t, g);
         do_cpl(t, sts[k], 512, 128, dn, dt, er, ec, et);
         chk("R7 status done", dn, 1);
         chk("R7 status err", er, 1);
         chk("R7 status code", ec, 4);
         chk("R7 status tag", et, t);
         chk("R7 freed", int'(outstanding), 0);
      end
   endtask

   task automatic t_spurious;
      int t, g, dn, dt, er, ec, et;
      do_req(64, t, g);
      do_cpl(5, 0, 64, 64, dn, dt, er, ec, et);
      chk("R8 spurious err", er, 1);
      chk("R8 spurious code", ec, 1);
      chk("R8 spurious tag", et, 5);
      chk("R8 no done", dn, 0);
      chk("R8 count unchanged", int'(outstanding), 1);
      do_cpl(0, 0, 64, 64, dn, dt, er, ec, et);
      chk("R8 state intact done", dn, 1);
      do_cpl(0, 0, 64, 64, dn, dt, er, ec, et);
      chk("R8 freed tag spurious", ec, 1);
   endtask

   task automatic t_exhaust;
      int t, g, dn, dt, er, ec, et;
      int bad = 0;
      for (int i = 0; i < 256; i++) begin
         do_req(32, t, g);
         if (g != 1 || t != i) bad++;
      end
      chk("R1 sequential grants", bad, 0);
      chk("R10 full count", int'(outstanding), 256);
      chk("R2 exhausted", int'(tags_exhausted), 1);
      do_req(32, t, g);
      chk("R2 no grant", g, 0);
      do_cpl(100, 0, 32, 32, dn, dt, er, ec, et);
      chk("R2 not exhausted", int'(tags_exhausted), 0);
      do_req(32, t, g);
      chk("R3 only freed tag", t, 100);
      bad = 0;
      for (int i = 0; i < 256; i++) begin
         do_cpl(i, 0, 32, 32, dn, dt, er, ec, et);
         if (dn != 1 || dt != i) bad++;
      end
      chk("R4 all closed", bad, 0);
      chk("R10 drained", int'(outstanding), 0);
   endtask

   task automatic t_timeout;
      int t, g, k;
      tmo_limit = 20'd20;
      do_req(64, t, g);
      k = 0;
      while (k < 100) begin
         @(negedge clk);
         k++;
         if (err_pulse) break;
      end
      chk("R9 timeout latency", k, 21);
      chk("R9 timeout code", int'(err_code), 2);
      chk("R9 timeout tag", int'(err_tag), t);
      chk("R9 freed", int'(outstanding), 0);
      tmo_limit = 20'd5000;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lowest();
      t_split();
      t_status();
      t_spurious();
      t_exhaust();
      t_timeout();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule